// File: doc/BRIEF.md
# DMA Channel Programming Register File

This block is the host-facing register set of a four-channel DMA controller of the classic byte-port kind. A host reaches it through a 4-bit port offset and an 8-bit data bus with separate write and read strobes, one access per clock. Each channel keeps a 16-bit address and a 16-bit transfer count, both as a base copy and a current copy, together with a 6-bit mode field. The shared part of the block holds the per-channel mask bits, a command byte, software request bits and a status byte.

Since every port is one byte wide, a 16-bit value is moved as two accesses to the same port. One byte-pointer flip-flop, shared by all address and count ports, decides whether an access reaches the low or the high byte. The software resets it before it programs a channel. The outputs hand the per-channel configuration, the mask vector and a channel-enable vector to a separate transfer engine.

Top module: `dma_regfile`

## Requirements
- R1: While reset is asserted and after it is released, the byte pointer selects the low byte, all four mask bits are 1, the command byte, the request bits, every address, count and mode value are 0, and chan_en_o is 0.
- R2: A write to offset 2n (n = 0..3) stores wdata into byte 0 (pointer low) or byte 1 (pointer high) of channel n's base address and current address alike; the other byte and the other channels stay unchanged.
- R3: A write to offset 2n+1 does the same for channel n's base count and current count.
- R4: A read of offset 2n or 2n+1 returns the low (pointer low) or high (pointer high) byte of channel n's current address or current count. Every read or write of any of the offsets 0x0 to 0x7 toggles the single shared byte pointer.
- R5: A write of any value to offset 0xC sets the byte pointer to low.
- R6: A write to offset 0xA sets mask bit wdata[1:0] to wdata[2] (1 = masked); the other mask bits are unchanged.
- R7: A write to offset 0xB stores wdata[7:2] as the mode of channel wdata[1:0], so data bit 4 (auto-initialise) appears as mode bit 2; the other channels' modes are unchanged.
- R8: A write to offset 0x8 stores the command byte. A read of offset 0x8 returns the request bits in data bits 7:4 and zero in bits 3:0. chan_en_o[n] is 1 exactly when mask bit n is 0 and command bit 2 (controller disable) is 0.
- R9: A write to offset 0x9 sets request bit wdata[1:0] to wdata[2].
- R10: A write to offset 0xD sets the pointer to low, clears the command byte and the request bits, and sets all four mask bits; addresses, counts and modes are kept. A read of 0xD returns 0.
- R11: A write to offset 0xE clears all mask bits; a write to offset 0xF loads the mask bits from wdata[3:0].
- R12: When read and write strobes are both high on an address or count port, the write takes effect, rdata_o shows the byte as it was before that write, and the pointer toggles once.
- R13: Reads of offsets 0x9, 0xA, 0xB, 0xC, 0xE and 0xF return 0, and reads of offsets 0x8 to 0xF leave the byte pointer unchanged; with neither strobe high, rdata_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| offset | input | 4 | Port offset |
| wdata | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the cycle rd_en is high |
| base_addr_o | output | 64 | Base address, 16 bits per channel, channel 0 in the low bits |
| cur_addr_o | output | 64 | Current address per channel |
| base_cnt_o | output | 64 | Base count per channel |
| cur_cnt_o | output | 64 | Current count per channel |
| mode_o | output | 24 | Mode, 6 bits per channel |
| mask_o | output | 4 | Channel mask bits, 1 = masked |
| cmd_o | output | 8 | Command byte |
| req_o | output | 4 | Software request bits |
| chan_en_o | output | 4 | Channel enable vector for the transfer engine |

## Verification
A read and a write can hit the same address or count port in one cycle, and both then depend on the one byte pointer. The bench raises both strobes on channel 0's address port with a known stored value. It checks that the returned byte is the old low byte, that the new byte has replaced it, and that a following read gets the high byte, which shows the pointer stepped once and not twice. A separate test interleaves a count write with a read of another channel's address port, to show that all channels share the one pointer.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

    localparam int DATA_W = 8;
    localparam int WORD_W = 2 * DATA_W;
    localparam int MODE_W = DATA_W - 2;
    localparam int OFF_W  = 4;

    // Control port offsets (bit 3 set); bit 3 clear selects a channel port.
    localparam logic [OFF_W-1:0] OFF_CMD     = 4'h8;
    localparam logic [OFF_W-1:0] OFF_REQ     = 4'h9;
    localparam logic [OFF_W-1:0] OFF_MASK1   = 4'hA;
    localparam logic [OFF_W-1:0] OFF_MODE    = 4'hB;
    localparam logic [OFF_W-1:0] OFF_CLRPTR  = 4'hC;
    localparam logic [OFF_W-1:0] OFF_MCLR    = 4'hD;
    localparam logic [OFF_W-1:0] OFF_UNMASK  = 4'hE;
    localparam logic [OFF_W-1:0] OFF_MASKALL = 4'hF;

    localparam int SET_BIT     = 2;  // set/clear bit in single-bit writes
    localparam int CMD_DIS_BIT = 2;  // controller disable in command byte

    typedef struct packed {
        logic [WORD_W-1:0] base_addr;
        logic [WORD_W-1:0] cur_addr;
        logic [WORD_W-1:0] base_cnt;
        logic [WORD_W-1:0] cur_cnt;
        logic [MODE_W-1:0] mode;
    } chan_regs_t;

    typedef struct packed {
        logic       chan_acc;   // read or write of a channel port
        logic       chan_wr;    // write of a channel port
        logic [1:0] chan_sel;
        logic       is_cnt;
        logic       wr_cmd;
        logic       wr_req;
        logic       wr_mask1;
        logic       wr_mode;
        logic       wr_clrptr;
        logic       wr_mclr;
        logic       wr_unmask;
        logic       wr_maskall;
        logic       rd_status;
    } port_dec_t;

    function automatic logic [WORD_W-1:0] put_byte(input logic [WORD_W-1:0] word,
                                                   input logic [DATA_W-1:0] b,
                                                   input logic hi);
        logic [WORD_W-1:0] r;
        r = word;
        if (hi) r[WORD_W-1:DATA_W] = b;
        else    r[DATA_W-1:0]      = b;
        return r;
    endfunction

endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode
    import dmareg_pkg::*;
(
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [OFF_W-1:0] offset,
    output port_dec_t        dec_o
);

    logic is_ctl;

    always_comb begin
        is_ctl           = offset[OFF_W-1];
        dec_o.chan_acc   = (wr_en | rd_en) & ~is_ctl;
        dec_o.chan_wr    = wr_en & ~is_ctl;
        dec_o.chan_sel   = offset[2:1];
        dec_o.is_cnt     = offset[0];
        dec_o.wr_cmd     = wr_en & (offset == OFF_CMD);
        dec_o.wr_req     = wr_en & (offset == OFF_REQ);
        dec_o.wr_mask1   = wr_en & (offset == OFF_MASK1);
        dec_o.wr_mode    = wr_en & (offset == OFF_MODE);
        dec_o.wr_clrptr  = wr_en & (offset == OFF_CLRPTR);
        dec_o.wr_mclr    = wr_en & (offset == OFF_MCLR);
        dec_o.wr_unmask  = wr_en & (offset == OFF_UNMASK);
        dec_o.wr_maskall = wr_en & (offset == OFF_MASKALL);
        dec_o.rd_status  = rd_en & (offset == OFF_CMD);
    end

endmodule

// File: rtl/dmareg_chan.sv
module dmareg_chan
    import dmareg_pkg::*;
#(
    parameter int CH_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_dec_t         dec,
    input  logic              byte_hi,
    input  logic [DATA_W-1:0] wdata,
    output chan_regs_t        regs_o
);

    localparam logic [1:0] MY_SEL = 2'(CH_ID);

    chan_regs_t regs_d, regs_q;
    logic       hit, addr_we, cnt_we, mode_we;

    always_comb begin
        hit     = dec.chan_wr & (dec.chan_sel == MY_SEL);
        addr_we = hit & ~dec.is_cnt;
        cnt_we  = hit & dec.is_cnt;
        mode_we = dec.wr_mode & (wdata[1:0] == MY_SEL);

        regs_d = regs_q;
        if (addr_we) begin
            regs_d.base_addr = put_byte(regs_q.base_addr, wdata, byte_hi);
            regs_d.cur_addr  = put_byte(regs_q.cur_addr,  wdata, byte_hi);
        end
        if (cnt_we) begin
            regs_d.base_cnt = put_byte(regs_q.base_cnt, wdata, byte_hi);
            regs_d.cur_cnt  = put_byte(regs_q.cur_cnt,  wdata, byte_hi);
        end
        if (mode_we) begin
            regs_d.mode = wdata[DATA_W-1:2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs_o = regs_q;

endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
    import dmareg_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [3:0]               offset,
    input  logic [7:0]               wdata,
    output logic [7:0]               rdata_o,
    output logic [NUM_CH*16-1:0]     base_addr_o,
    output logic [NUM_CH*16-1:0]     cur_addr_o,
    output logic [NUM_CH*16-1:0]     base_cnt_o,
    output logic [NUM_CH*16-1:0]     cur_cnt_o,
    output logic [NUM_CH*6-1:0]      mode_o,
    output logic [NUM_CH-1:0]        mask_o,
    output logic [7:0]               cmd_o,
    output logic [NUM_CH-1:0]        req_o,
    output logic [NUM_CH-1:0]        chan_en_o
);

    localparam int STAT_PAD = DATA_W - NUM_CH;

    typedef struct packed {
        logic              byte_hi;
        logic [NUM_CH-1:0] mask;
        logic [DATA_W-1:0] cmd;
        logic [NUM_CH-1:0] req;
    } ctl_t;

    port_dec_t         dec;
    ctl_t              ctl_d, ctl_q;
    chan_regs_t        regs [NUM_CH];
    logic [WORD_W-1:0] rd_word;
    logic [DATA_W-1:0] rd_byte;
    logic              byte_hi_w;

    dmareg_decode u_decode (
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .offset (offset),
        .dec_o  (dec)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        dmareg_chan #(.CH_ID(g)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .dec     (dec),
            .byte_hi (ctl_q.byte_hi),
            .wdata   (wdata),
            .regs_o  (regs[g])
        );
        assign base_addr_o[g*WORD_W +: WORD_W] = regs[g].base_addr;
        assign cur_addr_o [g*WORD_W +: WORD_W] = regs[g].cur_addr;
        assign base_cnt_o [g*WORD_W +: WORD_W] = regs[g].base_cnt;
        assign cur_cnt_o  [g*WORD_W +: WORD_W] = regs[g].cur_cnt;
        assign mode_o     [g*MODE_W +: MODE_W] = regs[g].mode;
    end

    // Next state of the shared control registers.
    always_comb begin
        ctl_d = ctl_q;
        if (dec.chan_acc)  ctl_d.byte_hi = ~ctl_q.byte_hi;
        if (dec.wr_clrptr) ctl_d.byte_hi = 1'b0;
        if (dec.wr_cmd)    ctl_d.cmd = wdata;
        if (dec.wr_req)    ctl_d.req[wdata[1:0]] = wdata[SET_BIT];
        if (dec.wr_mask1)  ctl_d.mask[wdata[1:0]] = wdata[SET_BIT];
        if (dec.wr_unmask) ctl_d.mask = '0;
        if (dec.wr_maskall) ctl_d.mask = wdata[NUM_CH-1:0];
        if (dec.wr_mclr) begin
            ctl_d.byte_hi = 1'b0;
            ctl_d.cmd     = '0;
            ctl_d.req     = '0;
            ctl_d.mask    = '1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q         <= '0;
            ctl_q.mask    <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // Read path: combinational from the current state.
    always_comb begin
        rd_word = dec.is_cnt ? regs[dec.chan_sel].cur_cnt : regs[dec.chan_sel].cur_addr;
        rd_byte = ctl_q.byte_hi ? rd_word[WORD_W-1:DATA_W] : rd_word[DATA_W-1:0];
        rdata_o = '0;
        if (rd_en && !offset[OFF_W-1]) rdata_o = rd_byte;
        else if (dec.rd_status)        rdata_o = {ctl_q.req, {STAT_PAD{1'b0}}};
    end

    assign byte_hi_w = ctl_q.byte_hi;
    assign mask_o    = ctl_q.mask;
    assign cmd_o     = ctl_q.cmd;
    assign req_o     = ctl_q.req;
    assign chan_en_o = ~ctl_q.mask & {NUM_CH{~ctl_q.cmd[CMD_DIS_BIT]}};

endmodule

// File: rtl/dmareg_chk.sv
module dmareg_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [3:0]        offset,
    input logic [7:0]        wdata,
    input logic [7:0]        rdata_o,
    input logic [NUM_CH-1:0] mask_o,
    input logic [7:0]        cmd_o,
    input logic [NUM_CH-1:0] req_o,
    input logic              byte_hi
);

    AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && !offset[3]) |=> (byte_hi != $past(byte_hi))); // R4

    AST_CLRPTR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && offset == 4'hC) |=> !byte_hi); // R5

    AST_MASK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && offset == 4'hA) |=> (mask_o[$past(wdata[1:0])] == $past(wdata[2]))); // R6

    AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && offset == 4'h8) |-> (rdata_o == {req_o, 4'h0})); // R8

    AST_MCLR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && offset == 4'hD) |=> (mask_o == '1 && cmd_o == 8'h00 && req_o == '0 && !byte_hi)); // R10

    AST_UNMASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && offset == 4'hE) |=> (mask_o == '0)); // R11

    AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && offset inside {4'h9, 4'hA, 4'hB, 4'hC, 4'hE, 4'hF}) |-> (rdata_o == 8'h00)); // R13

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rd_en) |=> ($stable(byte_hi) && $stable(mask_o) && $stable(cmd_o) && $stable(req_o))); // R13

endmodule

bind dma_regfile dmareg_chk #(.NUM_CH(NUM_CH)) u_dmareg_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .offset  (offset),
    .wdata   (wdata),
    .rdata_o (rdata_o),
    .mask_o  (mask_o),
    .cmd_o   (cmd_o),
    .req_o   (req_o),
    .byte_hi (byte_hi_w)
);

// File: tb/test_dma_regfile.sv
module test_dma_regfile;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 4;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 wr_en = 1'b0;
    logic                 rd_en = 1'b0;
    logic [3:0]           offset = '0;
    logic [7:0]           wdata = '0;
    logic [7:0]           rdata_o;
    logic [NUM_CH*16-1:0] base_addr_o, cur_addr_o, base_cnt_o, cur_cnt_o;
    logic [NUM_CH*6-1:0]  mode_o;
    logic [NUM_CH-1:0]    mask_o, req_o, chan_en_o;
    logic [7:0]           cmd_o;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_regfile #(.NUM_CH(NUM_CH)) i_dma_regfile (
        .clk, .rst_n, .wr_en, .rd_en, .offset, .wdata, .rdata_o,
        .base_addr_o, .cur_addr_o, .base_cnt_o, .cur_cnt_o,
        .mode_o, .mask_o, .cmd_o, .req_o, .chan_en_o
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] off, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; offset = off; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] off, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; offset = off;
        #1 d = rdata_o;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    function automatic logic [15:0] word_of(input logic [NUM_CH*16-1:0] v, input int ch);
        return v[ch*16 +: 16];
    endfunction

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 mask", 32'(mask_o), 32'hF);
        chk("R1 cmd", 32'(cmd_o), 32'h0);
        chk("R1 req", 32'(req_o), 32'h0);
        chk("R1 chan_en", 32'(chan_en_o), 32'h0);
        chk("R1 addr", 32'(cur_addr_o[31:0]), 32'h0);
        chk("R1 mode", 32'(mode_o), 32'h0);
        chk("R1 idle rdata", 32'(rdata_o), 32'h0);
        rd(4'h0, d);
        chk("R1 ch0 addr read", 32'(d), 32'h0);
        rd(4'h0, d);
    endtask

    task automatic t_addr_load();
        wr(4'hC, 8'h00);
        wr(4'h0, 8'h34);
        chk("R2 ch0 low byte", 32'(word_of(base_addr_o, 0)), 32'h0034);
        wr(4'h0, 8'h12);
        chk("R2 ch0 base", 32'(word_of(base_addr_o, 0)), 32'h1234);
        chk("R2 ch0 cur", 32'(word_of(cur_addr_o, 0)), 32'h1234);
        wr(4'h6, 8'hCD);
        wr(4'h6, 8'hAB);
        chk("R2 ch3 base", 32'(word_of(base_addr_o, 3)), 32'hABCD);
        chk("R2 ch1 untouched", 32'(word_of(cur_addr_o, 1)), 32'h0);
        chk("R2 ch3 count untouched", 32'(word_of(cur_cnt_o, 3)), 32'h0);
    endtask

    task automatic t_count_load();
        wr(4'hC, 8'h00);
        wr(4'h5, 8'hFF);
        wr(4'h5, 8'h00);
        chk("R3 ch2 base cnt", 32'(word_of(base_cnt_o, 2)), 32'h00FF);
        chk("R3 ch2 cur cnt", 32'(word_of(cur_cnt_o, 2)), 32'h00FF);
        chk("R3 ch2 addr untouched", 32'(word_of(cur_addr_o, 2)), 32'h0);
    endtask

    task automatic t_readback();
        logic [7:0] d;
        wr(4'hC, 8'h00);
        rd(4'h0, d); chk("R4 ch0 addr lo", 32'(d), 32'h34);
        rd(4'h0, d); chk("R4 ch0 addr hi", 32'(d), 32'h12);
        rd(4'h5, d); chk("R4 ch2 cnt lo", 32'(d), 32'hFF);
        rd(4'h5, d); chk("R4 ch2 cnt hi", 32'(d), 32'h00);
        // shared pointer: a write on one port moves the pointer for another
        wr(4'h1, 8'h11);
        rd(4'h6, d); chk("R4 shared pointer hi", 32'(d), 32'hAB);
        chk("R4 ch0 cnt lo", 32'(word_of(cur_cnt_o, 0)), 32'h0011);
    endtask

    task automatic t_clrptr();
        wr(4'hC, 8'h00);
        wr(4'h2, 8'h55);
        wr(4'hC, 8'hFF);
        wr(4'h2, 8'h66);
        chk("R5 ch1 addr after clear", 32'(word_of(cur_addr_o, 1)), 32'h0066);
    endtask

    task automatic t_mask();
        wr(4'hE, 8'h00);
        chk("R11 clear masks", 32'(mask_o), 32'h0);
        chk("R8 enables", 32'(chan_en_o), 32'hF);
        wr(4'hA, 8'h06);
        chk("R6 mask ch2", 32'(mask_o), 32'h4);
        chk("R8 enable ch2 off", 32'(chan_en_o), 32'hB);
        wr(4'hA, 8'h02);
        chk("R6 unmask ch2", 32'(mask_o), 32'h0);
        wr(4'hF, 8'hA5);
        chk("R11 load masks", 32'(mask_o), 32'h5);
        wr(4'hE, 8'h00);
    endtask

    task automatic t_mode();
        wr(4'hB, 8'h45);
        chk("R7 ch1 mode", 32'(mode_o[6 +: 6]), 32'h11);
        wr(4'hB, 8'h5B);
        chk("R7 ch3 mode", 32'(mode_o[18 +: 6]), 32'h16);
        chk("R7 ch3 autoinit", 32'(mode_o[18+2]), 32'h1);
        chk("R7 ch0 ch2 untouched", 32'({mode_o[0 +: 6], mode_o[12 +: 6]}), 32'h0);
    endtask

    task automatic t_cmd_status();
        logic [7:0] d;
        wr(4'h8, 8'h04);
        chk("R8 cmd", 32'(cmd_o), 32'h04);
        chk("R8 disabled", 32'(chan_en_o), 32'h0);
        wr(4'h9, 8'h05);
        chk("R9 req ch1", 32'(req_o), 32'h2);
        rd(4'h8, d);
        chk("R8 status", 32'(d), 32'h20);
        wr(4'h9, 8'h01);
        chk("R9 req clear", 32'(req_o), 32'h0);
        wr(4'h8, 8'h00);
        chk("R8 re-enabled", 32'(chan_en_o), 32'hF);
    endtask

    task automatic t_mclr();
        logic [7:0] d;
        wr(4'h9, 8'h07);
        wr(4'h8, 8'h10);
        wr(4'hC, 8'h00);
        wr(4'h3, 8'h22);
        wr(4'hD, 8'h00);
        chk("R10 mask", 32'(mask_o), 32'hF);
        chk("R10 cmd", 32'(cmd_o), 32'h0);
        chk("R10 req", 32'(req_o), 32'h0);
        chk("R10 addr kept", 32'(word_of(cur_addr_o, 0)), 32'h1234);
        chk("R10 mode kept", 32'(mode_o[6 +: 6]), 32'h11);
        rd(4'hD, d);
        chk("R10 read temp", 32'(d), 32'h0);
        rd(4'h0, d);
        chk("R10 pointer low", 32'(d), 32'h34);
    endtask

    task automatic t_same_cycle();
        logic [7:0] d;
        wr(4'hC, 8'h00);
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; offset = 4'h0; wdata = 8'h99;
        #1 d = rdata_o;
        @(posedge clk); #1;
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R12 old byte read", 32'(d), 32'h34);
        chk("R12 write applied", 32'(word_of(cur_addr_o, 0)), 32'h1299);
        rd(4'h0, d);
        chk("R12 single toggle", 32'(d), 32'h12);
    endtask

    task automatic t_no_toggle();
        logic [7:0] d;
        wr(4'hC, 8'h00);
        rd(4'h8, d);
        rd(4'hB, d); chk("R13 mode read zero", 32'(d), 32'h0);
        rd(4'hF, d); chk("R13 maskall read zero", 32'(d), 32'h0);
        wr(4'h9, 8'h00);
        rd(4'h0, d);
        chk("R13 pointer still low", 32'(d), 32'h99);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_addr_load();
        t_count_load();
        t_readback();
        t_clrptr();
        t_mask();
        t_mode();
        t_cmd_status();
        t_mclr();
        t_same_cycle();
        t_no_toggle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule